// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit interval timer. A prescaler divides the system clock into timer ticks. On each tick the count register either steps up by one or, when it already equals a software-programmed period value, returns to zero and reports a match. A 4-bit postscaler counts these matches. After the programmed number of matches it sets a sticky flag, and the flag drives the interrupt output when its enable bit is set.

Software uses a simple register port. A write strobe carries an address and data, and a separate read address returns data combinationally. The port reaches the count, the period, the control word (prescale select, run bit, postscale code) and a status word (flag and interrupt enable). The timer runs on internal clock cycles only.

Top module: `pm_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, control reads 0x00, status reads 0x00 and irq is 0. Register addresses are: 0 = count, 1 = period, 2 = control, 3 = status.
- R2: While control bit 2 (run) is 1, the count goes up by one on every prescaled tick. While run is 0, the count holds its value.
- R3: Control bits [1:0] set the prescale ratio: 00 gives a tick every clock, 01 every 4 clocks, and 10 or 11 every 16 clocks.
- R4: A tick that finds the count equal to the period makes the count 0 on that same edge and counts as one match. The count therefore runs P-1, P, 0, 1.
- R5: Control bits [6:3] hold a postscale code c, and the flag (status bit 0) is set on the (c+1)-th match. Suppose control is written with run=1 at edge E0 while the count is 0. The flag then first reads 1 after edge E0 + R*(c+1)*(P+1), where R is the prescale ratio and P is the period.
- R6: The flag is sticky. It stays 1 until software writes status with bit 0 = 0. A status write loads bit 0 (flag) and bit 1 (interrupt enable).
- R7: If a hardware flag set and a software status write land on the same edge, the set wins and the flag reads 1.
- R8: irq is 1 only when the flag and the interrupt enable (status bit 1) are both 1.
- R9: A write to the count or to control clears the prescaler and postscaler progress and cancels any tick in that cycle.
- R10: The period register can be written and read back. A period write leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall on the same clock edge: the postscaler completing its last match, which sets the flag, and a software status write that clears the flag. The bench starts a 1:1, period-3, single-match run. It times a status write of zero so that the write lands on the fourth tick edge after the run starts, which is the edge where the flag sets. It then reads status and expects the flag to be 1. A second clear, placed on a quiet edge after the timer is stopped, must leave the flag at 0. Together the two cases show that a set has priority over a clear and that the clear path itself still works.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;
  localparam int PSEL_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

  typedef struct packed {
    logic [POST_W-1:0] post_code;
    logic              run;
    logic [PSEL_W-1:0] psel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // terminal value of the prescaler counter for a select code
  function automatic logic [PRE_W-1:0] presc_limit(input logic [PSEL_W-1:0] sel);
    case (sel)
      2'b00:   presc_limit = PRE_W'(0);
      2'b01:   presc_limit = PRE_W'(3);
      default: presc_limit = PRE_W'(15);
    endcase
  endfunction

  // next value of a free-running up counter with an early wrap
  function automatic logic [PRE_W-1:0] wrap_inc(input logic [PRE_W-1:0] v,
                                               input logic [PRE_W-1:0] lim);
    wrap_inc = (v == lim) ? '0 : v + 1'b1;
  endfunction
endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler
  import pm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic [PSEL_W-1:0] sel,
  output logic              tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;
  logic             at_end;

  assign lim    = presc_limit(sel);
  assign at_end = (div_q == lim);
  assign tick   = run && !clear && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)     div_q <= '0;
    else if (clear) div_q <= '0;
    else if (run)   div_q <= wrap_inc(div_q, lim);
  end
endmodule

// File: rtl/pm_period_counter.sv
module pm_period_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] count_q;

  assign count = count_q;
  assign match = tick && (count_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (load)  count_q <= load_val;
    else if (match) count_q <= '0;
    else if (tick)  count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/pm_postscaler.sv
module pm_postscaler
  import pm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              match,
  input  logic [POST_W-1:0] code,
  output logic              fire
);
  logic [POST_W-1:0] seen_q;

  assign fire = match && (seen_q == code);

  always_ff @(posedge clk) begin
    if (!rst_n)     seen_q <= '0;
    else if (clear) seen_q <= '0;
    else if (match) seen_q <= fire ? '0 : seen_q + 1'b1;
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic             flag_q, ie_q;
  logic             cnt_wr, per_wr, ctrl_wr, st_wr, clr_prog;
  logic             tick, match, post_fire;
  logic [CNT_W-1:0] count_q;
  logic             run;
  logic             unused_wbits;

  assign cnt_wr   = wr_en && (wr_addr == A_COUNT);
  assign per_wr   = wr_en && (wr_addr == A_PERIOD);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign st_wr    = wr_en && (wr_addr == A_STATUS);
  assign clr_prog = cnt_wr || ctrl_wr;
  assign run      = ctrl_q.run;
  assign unused_wbits = ^wr_data[CNT_W-1:CTRL_W];

  pm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(clr_prog),
    .sel(ctrl_q.psel), .tick(tick)
  );

  pm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
    .load_val(wr_data), .period(period_q), .count(count_q), .match(match)
  );

  pm_postscaler u_post (
    .clk(clk), .rst_n(rst_n), .clear(clr_prog), .match(match),
    .code(ctrl_q.post_code), .fire(post_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (per_wr)  period_q <= wr_data;
      if (st_wr)   ie_q     <= wr_data[1];
      if (post_fire)  flag_q <= 1'b1;
      else if (st_wr) flag_q <= wr_data[0];
    end
  end

  assign irq = flag_q && ie_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_COUNT:  rd_data = count_q;
      A_PERIOD: rd_data = period_q;
      A_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
      default:  rd_data[1:0] = {ie_q, flag_q};
    endcase
  end
endmodule

// File: rtl/pm_timer_checker.sv
module pm_timer_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cnt_wr,
  input logic             ctrl_wr,
  input logic             st_wr,
  input logic             tick,
  input logic             match,
  input logic             post_fire,
  input logic [CNT_W-1:0] count_q,
  input logic             flag_q,
  input logic             ie_q,
  input logic             irq
);
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !match) |=> count_q == CNT_W'($past(count_q) + 1'b1));

  assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count_q));

  assert_match_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> count_q == '0);

  assert_fire_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |-> match);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !st_wr) |=> flag_q);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |=> flag_q);

  assert_irq_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> !irq);

  assert_write_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr || ctrl_wr) |-> !tick);
endmodule

bind pm_timer pm_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
  .st_wr(st_wr), .tick(tick), .match(match), .post_fire(post_fire),
  .count_q(count_q), .flag_q(flag_q), .ie_q(ie_q), .irq(irq)
);

// File: tb/pm_timer_test.sv
`timescale 1ns/1ps
module pm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {prescale sel, postscale code, period, expected cycles to flag}
  localparam logic [31:0] VECS [0:5] = '{
    {2'd0, 4'd0,  8'd3, 18'd4},
    {2'd1, 4'd0,  8'd3, 18'd16},
    {2'd2, 4'd2,  8'd1, 18'd96},
    {2'd3, 4'd1,  8'd0, 18'd32},
    {2'd0, 4'd15, 8'd2, 18'd48},
    {2'd1, 4'd3,  8'd5, 18'd96}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl(input logic [1:0] ps, input logic [3:0] post, input logic run);
    return {1'b0, post, run, ps};
  endfunction

  task automatic setup(input logic [7:0] per);
    wr(2, 8'h00); wr(1, per); wr(0, 8'h00); wr(3, 8'h00);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 count", v, 8'h00);
    rd(1, v); check("R1 period", v, 8'hFF);
    rd(2, v); check("R1 control", v, 8'h00);
    rd(3, v); check("R1 status", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'd0);

    // R3 R5 vector table
    foreach (VECS[k]) begin
      logic [1:0] ps; logic [3:0] po; logic [7:0] pe; int ex;
      ps = VECS[k][31:30]; po = VECS[k][29:26]; pe = VECS[k][25:18]; ex = int'(VECS[k][17:0]);
      setup(pe);
      wr(2, ctrl(ps, po, 1'b1));
      idle(ex - 1);
      rd(3, v); check("R5 flag not early", {7'd0, v[0]}, 8'd0);
      check("R8 irq off without flag", {7'd0, irq}, 8'd0);
      idle(1);
      rd(3, v); check("R3/R5 flag on time", {7'd0, v[0]}, 8'd1);
      check("R8 irq off without enable", {7'd0, irq}, 8'd0);
    end

    // R6 sticky after stop; R2 halt
    wr(2, ctrl(2'd0, 4'd0, 1'b0));
    rd(0, v);
    begin
      logic [7:0] held;
      held = v;
      idle(10);
      rd(0, v); check("R2 halted count", v, held);
    end
    rd(3, v); check("R6 flag sticky", {7'd0, v[0]}, 8'd1);

    // R8 interrupt gating
    wr(3, 8'h03); check("R8 irq with flag and enable", {7'd0, irq}, 8'd1);
    wr(3, 8'h02); check("R8 irq after clear", {7'd0, irq}, 8'd0);
    rd(3, v); check("R6 software clear", v, 8'h02);
    wr(3, 8'h00);

    // R4 count sequence and R2 stepping
    setup(8'd2);
    wr(2, ctrl(2'd0, 4'd0, 1'b1));
    idle(1); rd(0, v); check("R2 step 1", v, 8'd1);
    idle(1); rd(0, v); check("R4 reach period", v, 8'd2);
    idle(1); rd(0, v); check("R4 rollover to zero", v, 8'd0);
    idle(1); rd(0, v); check("R4 after rollover", v, 8'd1);

    // R10 period write does not disturb count
    wr(2, 8'h00); wr(0, 8'h21);
    wr(1, 8'h55);
    rd(1, v); check("R10 period readback", v, 8'h55);
    rd(0, v); check("R10 count unchanged", v, 8'h21);

    // R7 set and clear on the same edge
    setup(8'd3);
    wr(2, ctrl(2'd0, 4'd0, 1'b1));
    idle(3);
    wr(3, 8'h00);
    rd(3, v); check("R7 set wins over clear", {7'd0, v[0]}, 8'd1);
    wr(2, 8'h00);
    wr(3, 8'h00);
    rd(3, v); check("R6 clear on quiet edge", {7'd0, v[0]}, 8'd0);

    // R9 count write restarts the prescaler
    setup(8'hFF);
    wr(2, ctrl(2'd1, 4'd0, 1'b1));
    idle(2);
    wr(0, 8'd10);
    rd(0, v); check("R9 count loaded", v, 8'd10);
    idle(3); rd(0, v); check("R9 prescaler restarted", v, 8'd10);
    idle(1); rd(0, v); check("R9 first tick after load", v, 8'd11);

    // R9 count write restarts the postscaler
    setup(8'd1);
    wr(2, ctrl(2'd0, 4'd1, 1'b1));
    idle(2);
    wr(0, 8'd0);
    idle(3); rd(3, v); check("R9 postscaler restarted", {7'd0, v[0]}, 8'd0);
    idle(1); rd(3, v); check("R9 flag after two new matches", {7'd0, v[0]}, 8'd1);

    // R3 code 11 same as 10: count after 16 clocks
    setup(8'hFF);
    wr(2, ctrl(2'd3, 4'd0, 1'b1));
    idle(15); rd(0, v); check("R3 no tick before 16", v, 8'd0);
    idle(1);  rd(0, v); check("R3 tick at 16", v, 8'd1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule